// File: doc/BRIEF.md
# Bus-Activity Watchdog Timer

This block supervises a host processor by listening to its two-wire serial bus instead of a dedicated kick pin. Every time the processor completes a bus frame (a START condition, at least one full clock low/high cycle, then a STOP condition), the watchdog's timeout counter is cleared. If the counter reaches the selected period without such a frame, the block drives its reset output high. The output stays high for a fixed number of ticks, then releases, and counting starts again from zero.

The period comes from a two-bit field that the processor writes with a strobe. A write-protect pin freezes the field while it is high. One code of the field turns the watchdog off. Time is measured in pulses of a tick input, nominally one per millisecond. The bus lines and the protect pin arrive asynchronously and are synchronized inside the block. The block has no data stream, so there is no valid/ready handshake: every pin is a plain level or a one-cycle strobe.

Top module: `bus_watchdog`

## Requirements
- R1: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. Both are judged on the bus lines after two synchronizer flops, and at reset the lines are taken to be idle (high).
- R2: A frame made of START, SCL low, SCL high and then STOP clears the timeout counter to zero, whether or not data bits are clocked in between.
- R3: A STOP without a preceding START, a START never followed by a STOP, and a START followed by a STOP with no SCL low/high cycle between them all leave the counter running.
- R4: With reset low and the watchdog enabled, the output rises on the Nth tick after the last clear. N is TICKS_LONG for period code 2'b00, TICKS_MID for 2'b01 and TICKS_SHORT for 2'b10.
- R5: Once raised by a timeout, the reset output stays high for exactly HOLD_TICKS ticks and then falls. The counter restarts from zero at that moment.
- R6: A strobe on the period-write input while the synchronized protect pin is low loads the two-bit value, and it appears on the period output on the next cycle.
- R7: While the synchronized protect pin is high, period writes are refused and both the period output and the timeout length stay as they were.
- R8: Period code 2'b11 disables the watchdog. No timeout occurs and the counter is held at zero, so a later enabled period counts its full length.
- R9: Bus frames that complete while the reset output is high have no effect: the hold lasts its full length.
- R10: The reset output changes only in cycles in which the tick input is high.
- R11: After the block reset, the reset output is low, the period output is 2'b00 and the counter is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| scl_i | input | 1 | Serial bus clock line, asynchronous |
| sda_i | input | 1 | Serial bus data line, asynchronous |
| wp_i | input | 1 | Write-protect pin; high locks the period field |
| per_wdata_i | input | 2 | Period code to store (00 long, 01 mid, 10 short, 11 off) |
| per_we_i | input | 1 | One-cycle strobe that writes per_wdata_i |
| tick_i | input | 1 | One-cycle timebase pulse (nominally 1 ms) |
| wdt_rst_o | output | 1 | Watchdog reset output, active high |
| period_o | output | 2 | Currently stored period code |

## Verification
The bench builds the block with TICKS_LONG=12, TICKS_MID=7, TICKS_SHORT=3 and HOLD_TICKS=4 instead of the millisecond-scale defaults. With these values every period, every hold release and the one-tick edges on either side of each expiry can be reached in a few hundred ticks. At that scale the bench can show exactly where a frame moves the timeout, where a locked write fails to shorten or lengthen it, and that a frame during the hold does not cut the hold short.

// File: rtl/bus_wdt_pkg.sv
package bus_wdt_pkg;

  typedef enum logic [1:0] {
    PER_LONG  = 2'b00,
    PER_MID   = 2'b01,
    PER_SHORT = 2'b10,
    PER_OFF   = 2'b11
  } period_e;

  typedef enum logic [1:0] {
    FR_IDLE,
    FR_STARTED,
    FR_SCL_LOW,
    FR_ARMED
  } frame_e;

endpackage

// File: rtl/bus_wdt_sync.sv
module bus_wdt_sync #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/bus_wdt_frame.sv
module bus_wdt_frame
  import bus_wdt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic kick_o
);

  logic   scl_q, sda_q;
  logic   start_det, stop_det;
  frame_e st_q, st_d;

  // previous bus levels, reset to the idle (released) state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  // SDA edge while SCL held high on both samples
  assign start_det = scl_q && scl_s && sda_q && !sda_s;
  assign stop_det  = scl_q && scl_s && !sda_q && sda_s;

  always_comb begin
    st_d   = st_q;
    kick_o = 1'b0;
    if (start_det) begin
      st_d = FR_STARTED;
    end else begin
      unique case (st_q)
        FR_IDLE:    st_d = FR_IDLE;
        FR_STARTED: begin
          if (stop_det)    st_d = FR_IDLE;
          else if (!scl_s) st_d = FR_SCL_LOW;
        end
        FR_SCL_LOW: if (scl_s) st_d = FR_ARMED;
        FR_ARMED: begin
          if (stop_det) begin
            st_d   = FR_IDLE;
            kick_o = 1'b1;
          end
        end
        default: st_d = FR_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= FR_IDLE;
    else        st_q <= st_d;
  end

endmodule

// File: rtl/bus_wdt_period.sv
module bus_wdt_period
  import bus_wdt_pkg::*;
#(
  parameter logic [1:0] RST_CODE = PER_LONG
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lock_s,
  input  logic       we_i,
  input  logic [1:0] wdata_i,
  output logic [1:0] code_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              code_o <= RST_CODE;
    else if (we_i && !lock_s) code_o <= wdata_i;
  end

endmodule

// File: rtl/bus_wdt_timer.sv
module bus_wdt_timer
  import bus_wdt_pkg::*;
#(
  parameter int unsigned TICKS_LONG  = 1400,
  parameter int unsigned TICKS_MID   = 600,
  parameter int unsigned TICKS_SHORT = 200,
  parameter int unsigned HOLD_TICKS  = 200,
  parameter int unsigned CW          = 11,
  parameter int unsigned HW          = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          kick_i,
  input  logic [1:0]    code_i,
  output logic [CW-1:0] cnt_o,
  output logic          hold_o
);

  logic [CW-1:0] last_q;
  logic [HW-1:0] hold_cnt;

  // last count value before expiry for the selected period
  always_comb begin
    unique case (period_e'(code_i))
      PER_LONG:  last_q = CW'(TICKS_LONG - 1);
      PER_MID:   last_q = CW'(TICKS_MID - 1);
      PER_SHORT: last_q = CW'(TICKS_SHORT - 1);
      default:   last_q = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_o    <= '0;
      hold_cnt <= '0;
      hold_o   <= 1'b0;
    end else if (hold_o) begin
      if (tick_i) begin
        if (hold_cnt == HW'(HOLD_TICKS - 1)) begin
          hold_o   <= 1'b0;
          hold_cnt <= '0;
          cnt_o    <= '0;
        end else begin
          hold_cnt <= hold_cnt + 1'b1;
        end
      end
    end else if (period_e'(code_i) == PER_OFF || kick_i) begin
      cnt_o <= '0;
    end else if (tick_i) begin
      if (cnt_o >= last_q) begin
        hold_o   <= 1'b1;
        hold_cnt <= '0;
        cnt_o    <= '0;
      end else begin
        cnt_o <= cnt_o + 1'b1;
      end
    end
  end

endmodule

// File: rtl/bus_watchdog.sv
module bus_watchdog
  import bus_wdt_pkg::*;
#(
  parameter int unsigned TICKS_LONG  = 1400,
  parameter int unsigned TICKS_MID   = 600,
  parameter int unsigned TICKS_SHORT = 200,
  parameter int unsigned HOLD_TICKS  = 200,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       wp_i,
  input  logic [1:0] per_wdata_i,
  input  logic       per_we_i,
  input  logic       tick_i,
  output logic       wdt_rst_o,
  output logic [1:0] period_o
);

  localparam int unsigned MAX_LM = (TICKS_LONG > TICKS_MID) ? TICKS_LONG : TICKS_MID;
  localparam int unsigned MAX_T  = (MAX_LM > TICKS_SHORT) ? MAX_LM : TICKS_SHORT;
  localparam int unsigned CW     = $clog2(MAX_T + 1);
  localparam int unsigned HW     = $clog2(HOLD_TICKS + 1);

  logic [2:0]    raw_in, sync_out;
  logic          scl_s, sda_s, wp_s;
  logic          kick;
  logic [CW-1:0] cnt;

  assign raw_in = {wp_i, sda_i, scl_i};

  bus_wdt_sync #(
    .W       (3),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (3'b011)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (raw_in),
    .q_o   (sync_out)
  );

  assign scl_s = sync_out[0];
  assign sda_s = sync_out[1];
  assign wp_s  = sync_out[2];

  bus_wdt_frame u_frame (
    .clk    (clk),
    .rst_n  (rst_n),
    .scl_s  (scl_s),
    .sda_s  (sda_s),
    .kick_o (kick)
  );

  bus_wdt_period #(
    .RST_CODE (PER_LONG)
  ) u_period (
    .clk     (clk),
    .rst_n   (rst_n),
    .lock_s  (wp_s),
    .we_i    (per_we_i),
    .wdata_i (per_wdata_i),
    .code_o  (period_o)
  );

  bus_wdt_timer #(
    .TICKS_LONG  (TICKS_LONG),
    .TICKS_MID   (TICKS_MID),
    .TICKS_SHORT (TICKS_SHORT),
    .HOLD_TICKS  (HOLD_TICKS),
    .CW          (CW),
    .HW          (HW)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_i (tick_i),
    .kick_i (kick),
    .code_i (period_o),
    .cnt_o  (cnt),
    .hold_o (wdt_rst_o)
  );

endmodule

// File: rtl/bus_watchdog_checker.sv
module bus_watchdog_checker #(
  parameter int unsigned CW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          wp_s,
  input logic          we,
  input logic [1:0]    wdata,
  input logic          kick,
  input logic [CW-1:0] cnt,
  input logic [1:0]    period,
  input logic          rst_out
);

  // R2: a completed frame outside the hold clears the counter
  p_kick_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (kick && !rst_out) |=> (cnt == '0));

  // R6: an unlocked write lands on the period output
  p_write_loads_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !wp_s) |=> (period == $past(wdata)));

  // R7: a locked period field never moves
  p_locked_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wp_s |=> $stable(period));

  // R8: the off code never produces a timeout and holds the count at zero
  p_off_no_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (period == 2'b11 && !rst_out) |=> (!rst_out && cnt == '0));

  // R10: the reset output only moves on tick cycles
  p_rst_on_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(rst_out));

endmodule

bind bus_watchdog bus_watchdog_checker #(.CW(CW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .tick    (tick_i),
  .wp_s    (wp_s),
  .we      (per_we_i),
  .wdata   (per_wdata_i),
  .kick    (kick),
  .cnt     (cnt),
  .period  (period_o),
  .rst_out (wdt_rst_o)
);

// File: tb/sim_bus_watchdog.sv
`timescale 1ns/1ps
module sim_bus_watchdog;

  localparam int unsigned T_LONG  = 12;
  localparam int unsigned T_MID   = 7;
  localparam int unsigned T_SHORT = 3;
  localparam int unsigned T_HOLD  = 4;

  localparam int OP_TICK  = 0;
  localparam int OP_FRAME = 1;
  localparam int OP_WRITE = 2;
  localparam int OP_STOP  = 3;
  localparam int OP_START = 4;

  function automatic logic [14:0] ent(int op, int arg, int r, int p);
    return {3'(op), 8'(arg), 1'b0, 1'(r), 2'(p)};
  endfunction

  // write arg: bits [1:0] value, bit 2 protect pin level
  localparam int NVEC = 33;
  localparam logic [14:0] TBL [NVEC] = '{
    ent(OP_WRITE, 2, 0, 2),   // R6 short period
    ent(OP_TICK,  2, 0, 2),
    ent(OP_TICK,  1, 1, 2),   // R4 expiry on tick 3
    ent(OP_TICK,  3, 1, 2),   // R5 still held
    ent(OP_TICK,  1, 0, 2),   // R5 release
    ent(OP_TICK,  2, 0, 2),
    ent(OP_FRAME, 0, 0, 2),   // R2 minimal frame
    ent(OP_TICK,  2, 0, 2),
    ent(OP_FRAME, 8, 0, 2),   // R2 frame with data bits
    ent(OP_TICK,  2, 0, 2),
    ent(OP_WRITE, 5, 0, 2),   // R7 locked write of 01
    ent(OP_TICK,  1, 1, 2),   // R7 short period kept
    ent(OP_TICK,  4, 0, 2),
    ent(OP_WRITE, 1, 0, 1),   // R6 mid period
    ent(OP_TICK,  6, 0, 1),
    ent(OP_TICK,  1, 1, 1),   // R4 mid expiry
    ent(OP_TICK,  4, 0, 1),
    ent(OP_WRITE, 3, 0, 3),   // R8 off
    ent(OP_TICK, 20, 0, 3),   // R8 no timeout
    ent(OP_WRITE, 0, 0, 0),
    ent(OP_TICK, 11, 0, 0),   // R8 counter left at zero
    ent(OP_STOP,  0, 0, 0),   // R3 lone STOP
    ent(OP_TICK,  1, 1, 0),
    ent(OP_TICK,  4, 0, 0),
    ent(OP_TICK, 11, 0, 0),
    ent(OP_START, 0, 0, 0),   // R3 START without STOP
    ent(OP_TICK,  1, 1, 0),
    ent(OP_TICK,  4, 0, 0),
    ent(OP_WRITE, 7, 0, 0),   // R7 locked write of 11
    ent(OP_FRAME, 0, 0, 0),
    ent(OP_TICK, 11, 0, 0),
    ent(OP_TICK,  1, 1, 0),   // R4 long expiry
    ent(OP_TICK,  4, 0, 0)
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1, sda = 1'b1, wp = 1'b0;
  logic [1:0] wdata = 2'b00;
  logic       we = 1'b0, tick = 1'b0;
  logic       wdt_rst;
  logic [1:0] period;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bus_watchdog #(
    .TICKS_LONG (T_LONG),
    .TICKS_MID  (T_MID),
    .TICKS_SHORT(T_SHORT),
    .HOLD_TICKS (T_HOLD)
  ) u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl),
    .sda_i      (sda),
    .wp_i       (wp),
    .per_wdata_i(wdata),
    .per_we_i   (we),
    .tick_i     (tick),
    .wdt_rst_o  (wdt_rst),
    .period_o   (period)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
      repeat (2) @(negedge clk);
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic bus(input logic c, input logic d);
    @(negedge clk);
    scl = c;
    sda = d;
    repeat (4) @(negedge clk);
  endtask

  task automatic frame(input int nbits);
    bus(1'b1, 1'b0);                       // START
    for (int i = 0; i < nbits; i++) begin
      bus(1'b0, 1'(i % 2));
      bus(1'b1, 1'(i % 2));
    end
    bus(1'b0, 1'b0);
    bus(1'b1, 1'b0);
    bus(1'b1, 1'b1);                       // STOP
    repeat (6) @(negedge clk);
  endtask

  task automatic write_per(input logic [1:0] v, input logic lock);
    @(negedge clk) wp = lock;
    repeat (4) @(negedge clk);
    wdata = v;
    we = 1'b1;
    @(negedge clk) we = 1'b0;
    repeat (4) @(negedge clk) wp = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R11 reset output", int'(wdt_rst), 0);
    check("R11 reset period", int'(period), 0);

    for (int i = 0; i < NVEC; i++) begin
      automatic logic [14:0] e = TBL[i];
      automatic int op  = int'(e[14:12]);
      automatic int arg = int'(e[11:4]);
      automatic string tag;
      case (op)
        OP_TICK:  begin ticks(arg);                      tag = "R4 R5 R8 tick"; end
        OP_FRAME: begin frame(arg);                      tag = "R1 R2 frame"; end
        OP_WRITE: begin write_per(arg[1:0], arg[2]);     tag = "R6 R7 write"; end
        OP_STOP:  begin bus(1'b0, 1'b1); bus(1'b0, 1'b0); bus(1'b1, 1'b0); bus(1'b1, 1'b1);
                        tag = "R3 lone stop"; end
        default:  begin bus(1'b1, 1'b0); bus(1'b0, 1'b0); bus(1'b0, 1'b1); bus(1'b1, 1'b1);
                        tag = "R3 lone start"; end
      endcase
      check($sformatf("%s vec %0d rst", tag, i), int'(wdt_rst), int'(e[2]));
      check($sformatf("%s vec %0d period", tag, i), int'(period), int'(e[1:0]));
    end

    // R3: START immediately followed by STOP, no SCL cycle
    ticks(11);
    bus(1'b1, 1'b0);
    bus(1'b1, 1'b1);
    repeat (6) @(negedge clk);
    check("R3 start-stop without clock", int'(wdt_rst), 0);
    ticks(1);
    check("R3 start-stop no restart", int'(wdt_rst), 1);
    ticks(4);
    check("R5 release after hold", int'(wdt_rst), 0);

    // R9: frame during hold is ignored
    ticks(12);
    check("R4 long expiry", int'(wdt_rst), 1);
    ticks(2);
    frame(0);
    check("R9 frame in hold", int'(wdt_rst), 1);
    ticks(1);
    check("R9 hold continues", int'(wdt_rst), 1);
    ticks(1);
    check("R9 hold full length", int'(wdt_rst), 0);
    ticks(11);
    check("R5 count from release", int'(wdt_rst), 0);
    ticks(1);
    check("R5 full period after release", int'(wdt_rst), 1);
    ticks(4);

    // R10: no tick, no change in reset output during long bus activity
    ticks(11);
    frame(4);
    repeat (40) @(negedge clk);
    check("R10 idle without tick", int'(wdt_rst), 0);

    // R11: reset mid-run
    write_per(2'b10, 1'b0);
    ticks(2);
    @(negedge clk) rst_n = 1'b0;
    repeat (3) @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R11 period after reset", int'(period), 0);
    check("R11 output after reset", int'(wdt_rst), 0);
    ticks(11);
    check("R11 counter zero after reset", int'(wdt_rst), 0);
    ticks(1);
    check("R11 expiry after reset", int'(wdt_rst), 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule